// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for Clause 22 management frames on a two-wire MDIO bus. Software sets up a control register that holds the MDC divisor, stored as divisor minus one, and a flag that drops the 32-bit preamble. For a write it loads the data register and then writes the command register. The command word carries the read and write strobes, the PHY address and the register number.

After an accepted command, the controller produces MDC from the system clock and shifts the frame out MSB first. It raises busy in the status register until the last bit time has ended. On a read it lets go of MDIO for the turnaround and the data field, samples the PHY on each rising MDC edge, and loads the 16 received bits into the data register as busy drops.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, all four registers read 0, MDC is low and the MDIO output enable is low. The registers are word index 0 control, 1 command, 2 data and 3 status. The command register always reads 0.
- R2: A valid command write makes status bit 0 read 1 in the next cycle. The bit goes back to 0 once the last bit time of the frame has ended.
- R3: A write frame with preamble is 64 MDC periods long. It carries 32 ones, then 01, then opcode 01, then the 5-bit PHY address (command bits 9:5), then the 5-bit register number (bits 4:0), then turnaround 10, then the 16-bit data register value, all MSB first. The master drives MDIO in every bit time.
- R4: When control bit 8 is set, the frame leaves out the preamble and is 32 MDC periods long.
- R5: A read frame (command bit 15) uses opcode 10. The master drives the first 14 bits after any preamble and releases MDIO (output enable low) for the 2 turnaround and 16 data bit times.
- R6: On a read, MDIO is sampled on each rising MDC edge in the data field. Once busy has cleared, the data register returns those 16 bits, first bit in bit 15.
- R7: The MDC period is (control bits 9 and up + 1) system clocks. A field value of 0 behaves as 1, which gives a period of 2.
- R8: MDIO output changes only at a falling MDC edge or at frame start, and stays stable while MDC is high.
- R9: A command written while busy is 1 is ignored. The running frame, its length and the data register are unaffected.
- R10: If bits 15 and 14 are both set, a read is started. A command write with neither bit set starts nothing.
- R11: While idle, MDC is held low and the MDIO output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | BUS_W | Register write data |
| bus_rdata | output | BUS_W | Register read data (combinational from bus_addr) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_in | input | 1 | MDIO value seen on the pin |

## Verification
Transfers are run as writes and reads, with and without the preamble, at divisors 2 (reached through the clamped field value 0), 4, 6 and 40. These cases tell apart the frame length, opcode and turnaround coding, and the MDC period arithmetic. The PHY model returns asymmetric data words, so a bit-order or off-by-one sampling error shows up in the data register. Commands issued while busy, with both strobes set, and with no strobe set separate the accept logic from the shifter.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;
   localparam int PHY_AW    = 5;
   localparam int REG_AW    = 5;
   localparam int DATA_W    = 16;
   localparam int PRE_BITS  = 32;
   localparam int BODY_BITS = 2 + 2 + PHY_AW + REG_AW + 2 + DATA_W;
   localparam int FRAME_MAX = PRE_BITS + BODY_BITS;
   localparam int IDX_AW    = 2;

   localparam int CMD_RD_BIT   = 15;
   localparam int CMD_WR_BIT   = 14;
   localparam int CMD_PHY_LSB  = 5;
   localparam int CTRL_PRE_BIT = 8;
   localparam int CTRL_DIV_LSB = 9;

   localparam logic [IDX_AW-1:0] REG_CTRL = 2'd0;
   localparam logic [IDX_AW-1:0] REG_CMD  = 2'd1;
   localparam logic [IDX_AW-1:0] REG_DATA = 2'd2;
   localparam logic [IDX_AW-1:0] REG_STAT = 2'd3;

   localparam logic [1:0] START_CODE = 2'b01;
   localparam logic [1:0] OPC_READ   = 2'b10;
   localparam logic [1:0] OPC_WRITE  = 2'b01;
   localparam logic [1:0] TURN_WRITE = 2'b10;

   typedef enum logic {SH_IDLE = 1'b0, SH_RUN = 1'b1} sh_state_e;

   typedef struct packed {
      logic              is_read;
      logic [PHY_AW-1:0] phy;
      logic [REG_AW-1:0] regad;
   } mdio_cmd_t;
endpackage

// File: rtl/mdio_clk_gen.sv
`timescale 1ns/1ps
module mdio_clk_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_m1,
   output logic             mdc,
   output logic             rise_evt,
   output logic             fall_evt
);
   localparam logic [DIV_W-1:0] MIN_DIV_M1 = DIV_W'(1);

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] div_eff;
   logic [DIV_W-1:0] half_pt;
   logic             mdc_q;

   always_comb begin
      div_eff  = (div_m1 == '0) ? MIN_DIV_M1 : div_m1;
      half_pt  = div_eff >> 1;
      rise_evt = run && (cnt_q == half_pt);
      fall_evt = run && (cnt_q == div_eff);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else begin
         cnt_q <= (cnt_q == div_eff) ? '0 : cnt_q + MIN_DIV_M1;
         if (rise_evt)      mdc_q <= 1'b1;
         else if (fall_evt) mdc_q <= 1'b0;
      end
   end

   assign mdc = mdc_q;

   AST_RISE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      rise_evt |=> mdc_q) else $error("rise event did not raise MDC"); // R7
   AST_FALL_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      fall_evt |-> mdc_q) else $error("fall event while MDC low"); // R7
endmodule

// File: rtl/mdio_regs.sv
`timescale 1ns/1ps
module mdio_regs
   import mdio_mgmt_pkg::*;
#(
   parameter int BUS_W       = 32,
   parameter int DIV_W       = 8,
   parameter bit PRE_SKIP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_AW-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   output logic [BUS_W-1:0]  rdata,
   input  logic              busy,
   input  logic              rd_done,
   input  logic [DATA_W-1:0] rd_word,
   output logic [DIV_W-1:0]  div_m1,
   output logic              pre_skip,
   output logic              start,
   output mdio_cmd_t         cmd,
   output logic [DATA_W-1:0] wr_word
);
   localparam int DIV_MSB = CTRL_DIV_LSB + DIV_W - 1;

   logic [DIV_W-1:0]  div_q;
   logic              pre_q;
   logic [DATA_W-1:0] data_q;
   logic              ctrl_hit, cmd_hit, data_hit;
   logic              unused_wdata;

   assign unused_wdata = ^wdata;

   always_comb begin
      ctrl_hit  = wr_en && (addr == REG_CTRL);
      cmd_hit   = wr_en && (addr == REG_CMD);
      data_hit  = wr_en && (addr == REG_DATA);
      start     = cmd_hit && !busy && (wdata[CMD_RD_BIT] || wdata[CMD_WR_BIT]);
      cmd.is_read = wdata[CMD_RD_BIT];
      cmd.phy     = wdata[CMD_PHY_LSB +: PHY_AW];
      cmd.regad   = wdata[0 +: REG_AW];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        div_q <= '0;
      else if (ctrl_hit) div_q <= wdata[DIV_MSB:CTRL_DIV_LSB];
   end

   generate
      if (PRE_SKIP_EN) begin : g_pre_skip
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        pre_q <= 1'b0;
            else if (ctrl_hit) pre_q <= wdata[CTRL_PRE_BIT];
         end
      end else begin : g_pre_always
         assign pre_q = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        data_q <= '0;
      else if (rd_done)  data_q <= rd_word;
      else if (data_hit) data_q <= wdata[DATA_W-1:0];
   end

   always_comb begin
      rdata = '0;
      case (addr)
         REG_CTRL: begin
            rdata[DIV_MSB:CTRL_DIV_LSB] = div_q;
            rdata[CTRL_PRE_BIT]         = pre_q;
         end
         REG_DATA: rdata[DATA_W-1:0] = data_q;
         REG_STAT: rdata[0]          = busy;
         default:  rdata = '0;
      endcase
   end

   assign div_m1   = div_q;
   assign pre_skip = pre_q;
   assign wr_word  = data_q;

   AST_DATA_LOADS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> (data_q == $past(rd_word))) else $error("capture not loaded"); // R6
endmodule

// File: rtl/mdio_shifter.sv
`timescale 1ns/1ps
module mdio_shifter
   import mdio_mgmt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  mdio_cmd_t         cmd,
   input  logic [DATA_W-1:0] wr_word,
   input  logic              pre_skip,
   input  logic              rise_evt,
   input  logic              fall_evt,
   input  logic              mdio_in,
   output logic              busy,
   output logic              mdio_out,
   output logic              mdio_oe,
   output logic              rd_done,
   output logic [DATA_W-1:0] rd_word
);
   localparam int IDX_W = $clog2(FRAME_MAX);
   localparam logic [IDX_W-1:0] ONE        = IDX_W'(1);
   localparam logic [IDX_W-1:0] LAST_FULL  = IDX_W'(FRAME_MAX - 1);
   localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(BODY_BITS - 1);
   localparam logic [IDX_W-1:0] TA_BACK    = IDX_W'(DATA_W + 1);
   localparam logic [IDX_W-1:0] DATA_BACK  = IDX_W'(DATA_W - 1);

   sh_state_e          st_q;
   logic [FRAME_MAX-1:0] frame_q;
   logic [IDX_W-1:0]   idx_q, last_q;
   logic               rd_q, oe_q;
   logic [DATA_W-1:0]  cap_q;
   logic [BODY_BITS-1:0] body;
   logic               at_last, in_data;
   logic [IDX_W-1:0]   ta_idx, data_idx;

   always_comb begin
      if (cmd.is_read)
         body = {START_CODE, OPC_READ, cmd.phy, cmd.regad, 2'b00, {DATA_W{1'b0}}};
      else
         body = {START_CODE, OPC_WRITE, cmd.phy, cmd.regad, TURN_WRITE, wr_word};
      ta_idx   = last_q - TA_BACK;
      data_idx = last_q - DATA_BACK;
      at_last  = (idx_q == last_q);
      in_data  = (idx_q >= data_idx);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SH_IDLE;
         frame_q <= '0;
         idx_q   <= '0;
         last_q  <= '0;
         rd_q    <= 1'b0;
         oe_q    <= 1'b0;
         cap_q   <= '0;
      end else begin
         case (st_q)
            SH_IDLE: begin
               if (start) begin
                  st_q    <= SH_RUN;
                  frame_q <= pre_skip ? {body, {PRE_BITS{1'b0}}}
                                      : {{PRE_BITS{1'b1}}, body};
                  idx_q   <= '0;
                  last_q  <= pre_skip ? LAST_SHORT : LAST_FULL;
                  rd_q    <= cmd.is_read;
                  oe_q    <= 1'b1;
                  cap_q   <= '0;
               end
            end
            default: begin
               if (rise_evt && rd_q && in_data)
                  cap_q <= {cap_q[DATA_W-2:0], mdio_in};
               if (fall_evt) begin
                  if (at_last) begin
                     st_q <= SH_IDLE;
                     oe_q <= 1'b0;
                  end else begin
                     idx_q   <= idx_q + ONE;
                     frame_q <= frame_q << 1;
                     if (rd_q && ((idx_q + ONE) == ta_idx))
                        oe_q <= 1'b0;
                  end
               end
            end
         endcase
      end
   end

   assign busy     = (st_q == SH_RUN);
   assign mdio_out = busy & frame_q[FRAME_MAX-1];
   assign mdio_oe  = oe_q;
   assign rd_done  = busy && fall_evt && at_last && rd_q;
   assign rd_word  = cap_q;

   AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy) else $error("start did not raise busy"); // R2
   AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start) else $error("command accepted while busy"); // R9
   AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_q && in_data) |-> !oe_q) else $error("master drives read data"); // R5
endmodule

// File: rtl/mdio_mgmt_master.sv
`timescale 1ns/1ps
module mdio_mgmt_master
   import mdio_mgmt_pkg::*;
#(
   parameter int BUS_W       = 32,
   parameter int DIV_W       = 8,
   parameter bit PRE_SKIP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              mdc,
   output logic              mdio_out,
   output logic              mdio_oe,
   input  logic              mdio_in
);
   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
      if (BUS_W < CTRL_DIV_LSB + DIV_W || BUS_W < DATA_W) begin : g_bad_bus
         $error("BUS_W too narrow for control or data field");
      end
   endgenerate

   logic              busy, start, pre_skip, rd_done, rise_evt, fall_evt;
   logic [DIV_W-1:0]  div_m1;
   logic [DATA_W-1:0] wr_word, rd_word;
   mdio_cmd_t         cmd;

   mdio_regs #(.BUS_W(BUS_W), .DIV_W(DIV_W), .PRE_SKIP_EN(PRE_SKIP_EN)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .rdata(bus_rdata), .busy(busy), .rd_done(rd_done),
      .rd_word(rd_word), .div_m1(div_m1), .pre_skip(pre_skip), .start(start),
      .cmd(cmd), .wr_word(wr_word)
   );

   mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
      .clk(clk), .rst_n(rst_n), .run(busy), .div_m1(div_m1),
      .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
   );

   mdio_shifter u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .wr_word(wr_word),
      .pre_skip(pre_skip), .rise_evt(rise_evt), .fall_evt(fall_evt),
      .mdio_in(mdio_in), .busy(busy), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
      .rd_done(rd_done), .rd_word(rd_word)
   );

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe)) else $error("bus active while idle"); // R11
   AST_OUT_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)))
      else $error("MDIO moved while MDC high"); // R8
endmodule

// File: tb/mdio_mgmt_master_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_master_bench;
   localparam int CLK_PERIOD = 10;
   localparam int BUS_W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [BUS_W-1:0] bus_wdata = '0;
   logic [BUS_W-1:0] bus_rdata;
   logic mdc, mdio_out, mdio_oe;
   logic mdio_in = 1'b1;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   int rise_cnt = 0;
   int cur_n = 64;
   logic [15:0] phy_word = '0;
   logic rec_bit [0:63];
   logic rec_oe  [0:63];
   time t_prev = 0, t_last = 0;
   int stab_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mdio_mgmt_master u_mdio_mgmt_master (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
      .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
   );

   // Bus-side recorder: one sample per rising MDC edge
   initial begin
      forever begin
         @(posedge mdc);
         if (rise_cnt < 64) begin
            rec_bit[rise_cnt] = mdio_out;
            rec_oe[rise_cnt]  = mdio_oe;
         end
         rise_cnt = rise_cnt + 1;
         t_prev = t_last;
         t_last = $time;
      end
   end

   // PHY model: presents read data after each falling MDC edge
   initial begin
      forever begin
         @(negedge mdc);
         if (rise_cnt >= cur_n - 16 && rise_cnt < cur_n)
            mdio_in = phy_word[15 - (rise_cnt - (cur_n - 16))];
         else
            mdio_in = 1'b1;
      end
   end

   // Stability monitor for R8
   initial begin
      logic pm, po;
      pm = 1'b0; po = 1'b0;
      forever begin
         @(negedge clk);
         if (mdc && pm && (mdio_out !== po)) stab_err = stab_err + 1;
         pm = mdc; po = mdio_out;
      end
   end

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         failures = failures + 1;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int i = 0; i < 6000; i++) begin
         @(negedge clk);
         bus_read(2'd3, s);
         if (s[0] == 1'b0) return;
      end
   endtask

   function automatic logic [63:0] mk_frame(input bit pre, input bit rd, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] d);
      logic [31:0] body;
      body = {2'b01, rd ? 2'b10 : 2'b01, phy, rg, rd ? 2'b00 : 2'b10, rd ? 16'h0 : d};
      return pre ? {32'hFFFF_FFFF, body} : {body, 32'h0};
   endfunction

   // Generic transfer: program, launch, wait, compare
   task automatic xfer(input string req, input bit skip_pre, input bit rd, input bit both,
                       input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d,
                       input logic [7:0] div_field, input int exp_period, input logic [15:0] pword);
      logic [31:0] s, cmdw;
      logic [63:0] fr;
      int n, bad, oebad;
      n = skip_pre ? 32 : 64;
      cur_n = n; phy_word = pword; rise_cnt = 0;
      fr = mk_frame(!skip_pre, rd, phy, rg, d);
      bus_write(2'd0, {15'h0, div_field, skip_pre, 8'h0});
      if (!rd) bus_write(2'd2, {16'h0, d});
      cmdw = {16'h0, (rd | both), (!rd | both), 4'h0, phy, rg};
      bus_write(2'd1, cmdw);
      bus_read(2'd3, s);
      chk("R2", "busy next cycle", s[0], 1);
      wait_idle();
      bus_read(2'd3, s);
      chk("R2", "busy cleared", s[0], 0);
      chk(skip_pre ? "R4" : "R3", "MDC edge count", rise_cnt, n);
      bad = 0; oebad = 0;
      for (int i = 0; i < n; i++) begin
         if (rd && i >= n - 18) begin
            if (rec_oe[i] !== 1'b0) oebad = oebad + 1;
         end else begin
            if (rec_bit[i] !== fr[63 - i]) bad = bad + 1;
            if (rec_oe[i] !== 1'b1) oebad = oebad + 1;
         end
      end
      chk(rd ? "R5" : "R3", "frame bit mismatches", bad, 0);
      chk("R5", "output enable mismatches", oebad, 0);
      chk("R7", "MDC period", (t_last - t_prev) / CLK_PERIOD, exp_period);
      chk("R8", "MDIO changes while MDC high", stab_err, 0);
      bus_read(2'd2, s);
      chk("R6", "data register", s[15:0], rd ? pword : d);
      bus_read(2'd0, s);
      chk("R1", "control readback", s, {15'h0, div_field, skip_pre, 8'h0});
   endtask

   task automatic t_reset();
      logic [31:0] s;
      for (int a = 0; a < 4; a++) begin
         bus_read(a[1:0], s);
         chk("R1", "register after reset", s, 0);
      end
      chk("R11", "MDC idle", mdc, 0);
      chk("R11", "OE idle", mdio_oe, 0);
   endtask

   task automatic t_write_full();   xfer("R3", 0, 0, 0, 5'h11, 5'h06, 16'hA53C, 8'd3, 4, 16'h0); endtask
   task automatic t_read_short();   xfer("R6", 1, 1, 0, 5'h0B, 5'h1D, 16'h0, 8'd5, 6, 16'hC3A1); endtask
   task automatic t_read_full40();  xfer("R7", 0, 1, 0, 5'h01, 5'h01, 16'h0, 8'd39, 40, 16'h5A0F); endtask
   task automatic t_clamp();        xfer("R7", 1, 0, 0, 5'h1F, 5'h00, 16'h8001, 8'd0, 2, 16'h0); endtask
   task automatic t_both();         xfer("R10", 1, 1, 1, 5'h02, 5'h13, 16'h0, 8'd2, 3, 16'h3C96); endtask

   task automatic t_ignore_busy();
      logic [31:0] s;
      logic [63:0] fr;
      int bad;
      cur_n = 32; phy_word = 16'hFFFF; rise_cnt = 0;
      fr = mk_frame(0, 0, 5'h07, 5'h09, 16'h1234);
      bus_write(2'd0, {15'h0, 8'd3, 1'b1, 8'h0});
      bus_write(2'd2, 32'h1234);
      bus_write(2'd1, {16'h0, 2'b01, 4'h0, 5'h07, 5'h09});
      bus_write(2'd1, {16'h0, 2'b10, 4'h0, 5'h1A, 5'h1B});
      wait_idle();
      chk("R9", "edge count after ignored command", rise_cnt, 32);
      bad = 0;
      for (int i = 0; i < 32; i++) if (rec_bit[i] !== fr[63 - i]) bad = bad + 1;
      chk("R9", "frame unchanged", bad, 0);
      bus_read(2'd2, s);
      chk("R9", "data register kept", s[15:0], 16'h1234);
      repeat (20) @(negedge clk);
      bus_read(2'd3, s);
      chk("R9", "no second frame", s[0], 0);
   endtask

   task automatic t_no_strobe();
      logic [31:0] s;
      rise_cnt = 0;
      bus_write(2'd1, {16'h0, 2'b00, 4'h0, 5'h03, 5'h04});
      bus_read(2'd3, s);
      chk("R10", "no strobe stays idle", s[0], 0);
      repeat (30) @(negedge clk);
      chk("R10", "no MDC edges", rise_cnt, 0);
      chk("R11", "MDC low while idle", mdc, 0);
      bus_read(2'd1, s);
      chk("R1", "command reads zero", s, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         failures = failures + 1;
         checks = checks + 1;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_full();
      t_read_short();
      t_read_full40();
      t_clamp();
      t_both();
      t_ignore_busy();
      t_no_strobe();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule